// File: doc/BRIEF.md
# Route-Filtered QoS Remapper

This block sits on the request path between an on-chip interconnect and an AXI memory port. It takes a route ID, a thread class (low or high) and a 3-bit source priority for each request. From these it produces a 4-bit AXI QoS value. Three programmable route filters compare the route ID against a value under a mask. The result picks one of four translation tables, either the default table or the table for range 1, 2 or 3. The thread class picks which set of four tables is used, so eight tables exist in all.

A small write/read register port holds the filter settings and the tables. The translated QoS and the index of the table that was used are registered, and they appear one cycle after the request. A two-state output machine tracks this. State OUT_IDLE means no result is presented. State OUT_ISSUE means a result is presented and out_valid is high. The transition OUT_IDLE to OUT_ISSUE is taken when in_valid is high. OUT_ISSUE stays in OUT_ISSUE on a further in_valid. OUT_ISSUE returns to OUT_IDLE when in_valid is low. OUT_IDLE stays in OUT_IDLE while in_valid is low.

Top module: `qos_remap_top`

## Requirements
- R1: Filter k (k = 0, 1, 2, serving range k+1) is stored at register address k with match value in bits [11:0], mask in bits [23:12] and enable in bit 24. It hits when enabled and ((in_route ^ value) & mask) == 0, so a zero mask hits every route.
- R2: When no enabled filter hits, the default table of the request's class is used. out_table is {in_class, sel}, where sel is 0 for default and n for range n.
- R3: When several filters hit, the lowest-numbered range is used.
- R4: in_class = 1 selects the high-class table set and in_class = 0 the low-class set. The two sets are independent.
- R5: A table is a 32-bit register whose entry i, at bits [4i+3:4i], is the QoS returned for in_prio = i.
- R6: After reset, every table reads 32'h76543210 (entry i = i), every filter reads 0 (disabled), and out_valid is low.
- R7: out_valid is high in exactly the cycle after each cycle with in_valid high, and carries that request's result. out_qos and out_table hold their values while no request is taken.
- R8: A register write in the same cycle as a request does not affect that request. It affects every later request.
- R9: Tables are at address 8 + {class, sel}, and reg_rdata returns the addressed register combinationally. Filter reads return only bits [24:0], with the rest zero. Writes to addresses 3 to 7 are ignored, and those addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| in_route | input | 12 | Route ID of the request |
| in_class | input | 1 | Thread class, 1 = high |
| in_prio | input | 3 | Interconnect-side priority |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| out_valid | output | 1 | Result present this cycle |
| out_qos | output | 4 | Translated AXI QoS |
| out_table | output | 3 | Table used, {class, sel} |

## Verification
The two functions that can fall in the same cycle are a table or filter write and a request that looks up that same register. The bench drives reg_we and in_valid together on the default low-class table with a request that hits no filter. The result must carry the old entry, and the next request must carry the new one. The scoreboard computes both expected values from its own copy of the registers, taking the copy as it stood before the write.

// File: rtl/qos_remap_pkg.sv
package qos_remap_pkg;

    typedef enum logic {
        OUT_IDLE  = 1'b0,
        OUT_ISSUE = 1'b1
    } remap_state_e;

endpackage

// File: rtl/qos_route_filter.sv
module qos_route_filter #(
    parameter int ROUTE_W = 12
) (
    input  logic [2*ROUTE_W:0]   cfg,
    input  logic [ROUTE_W-1:0]   route,
    output logic                 hit
);
    logic [ROUTE_W-1:0] match_val;
    logic [ROUTE_W-1:0] match_mask;
    logic               enabled;

    assign match_val  = cfg[ROUTE_W-1:0];
    assign match_mask = cfg[2*ROUTE_W-1:ROUTE_W];
    assign enabled    = cfg[2*ROUTE_W];

    assign hit = enabled && (((route ^ match_val) & match_mask) == '0);
endmodule

// File: rtl/qos_remap_regs.sv
module qos_remap_regs #(
    parameter int ROUTE_W   = 12,
    parameter int PRIO_W    = 3,
    parameter int QOS_W     = 4,
    parameter int NUM_RANGE = 3,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    localparam int FILT_BITS = 2*ROUTE_W + 1,
    localparam int NUM_TAB   = 2*(NUM_RANGE + 1)
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                reg_we,
    input  logic [ADDR_W-1:0]                   reg_addr,
    input  logic [DATA_W-1:0]                   reg_wdata,
    output logic [DATA_W-1:0]                   reg_rdata,
    output logic [NUM_RANGE-1:0][FILT_BITS-1:0] filt_q,
    output logic [NUM_TAB-1:0][DATA_W-1:0]      tab_q
);
    localparam int TAB_BASE = 2**(ADDR_W-1);
    localparam int ENTRIES  = 2**PRIO_W;

    function automatic logic [DATA_W-1:0] identity_word();
        logic [DATA_W-1:0] w;
        w = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            w[i*QOS_W +: QOS_W] = QOS_W'(i);
        end
        return w;
    endfunction

    for (genvar k = 0; k < NUM_RANGE; k++) begin : g_filt
        always_ff @(posedge clk) begin
            if (rst) begin
                filt_q[k] <= '0;
            end else if (reg_we && reg_addr == ADDR_W'(k)) begin
                filt_q[k] <= reg_wdata[FILT_BITS-1:0];
            end
        end
    end

    for (genvar t = 0; t < NUM_TAB; t++) begin : g_tab
        always_ff @(posedge clk) begin
            if (rst) begin
                tab_q[t] <= identity_word();
            end else if (reg_we && reg_addr == ADDR_W'(TAB_BASE + t)) begin
                tab_q[t] <= reg_wdata;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < NUM_RANGE; k++) begin
            if (reg_addr == ADDR_W'(k)) begin
                reg_rdata = DATA_W'(filt_q[k]);
            end
        end
        for (int t = 0; t < NUM_TAB; t++) begin
            if (reg_addr == ADDR_W'(TAB_BASE + t)) begin
                reg_rdata = tab_q[t];
            end
        end
    end
endmodule

// File: rtl/qos_table_select.sv
module qos_table_select #(
    parameter int PRIO_W    = 3,
    parameter int QOS_W     = 4,
    parameter int NUM_RANGE = 3,
    parameter int DATA_W    = 32,
    localparam int NUM_TAB  = 2*(NUM_RANGE + 1),
    localparam int SEL_W    = $clog2(NUM_RANGE + 1),
    localparam int TBL_W    = SEL_W + 1
) (
    input  logic [NUM_RANGE-1:0]           hits,
    input  logic                           cls,
    input  logic [PRIO_W-1:0]              prio,
    input  logic [NUM_TAB-1:0][DATA_W-1:0] tab_q,
    output logic [QOS_W-1:0]               qos,
    output logic [TBL_W-1:0]               tbl
);
    logic [SEL_W-1:0] sel;

    always_comb begin
        sel = '0;
        for (int k = NUM_RANGE - 1; k >= 0; k--) begin
            if (hits[k]) begin
                sel = SEL_W'(k + 1);
            end
        end
        tbl = {cls, sel};
        qos = tab_q[tbl][prio*QOS_W +: QOS_W];
    end
endmodule

// File: rtl/qos_remap_top.sv
module qos_remap_top #(
    parameter int ROUTE_W   = 12,
    parameter int PRIO_W    = 3,
    parameter int QOS_W     = 4,
    parameter int NUM_RANGE = 3,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic [ROUTE_W-1:0]            in_route,
    input  logic                          in_class,
    input  logic [PRIO_W-1:0]             in_prio,
    input  logic                          reg_we,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [DATA_W-1:0]             reg_wdata,
    output logic [DATA_W-1:0]             reg_rdata,
    output logic                          out_valid,
    output logic [QOS_W-1:0]              out_qos,
    output logic [$clog2(NUM_RANGE+1):0]  out_table
);
    import qos_remap_pkg::*;

    localparam int FILT_BITS = 2*ROUTE_W + 1;
    localparam int NUM_TAB   = 2*(NUM_RANGE + 1);
    localparam int TBL_W     = $clog2(NUM_RANGE + 1) + 1;

    logic [NUM_RANGE-1:0][FILT_BITS-1:0] filt_q;
    logic [NUM_TAB-1:0][DATA_W-1:0]      tab_q;
    logic [NUM_RANGE-1:0]                hits;
    logic [QOS_W-1:0]                    qos_d;
    logic [TBL_W-1:0]                    tbl_d;
    remap_state_e                        state_q, state_d;

    qos_remap_regs #(
        .ROUTE_W(ROUTE_W), .PRIO_W(PRIO_W), .QOS_W(QOS_W),
        .NUM_RANGE(NUM_RANGE), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .filt_q(filt_q), .tab_q(tab_q)
    );

    for (genvar k = 0; k < NUM_RANGE; k++) begin : g_match
        qos_route_filter #(.ROUTE_W(ROUTE_W)) u_filt (
            .cfg(filt_q[k]), .route(in_route), .hit(hits[k])
        );
    end

    qos_table_select #(
        .PRIO_W(PRIO_W), .QOS_W(QOS_W), .NUM_RANGE(NUM_RANGE), .DATA_W(DATA_W)
    ) u_sel (
        .hits(hits), .cls(in_class), .prio(in_prio), .tab_q(tab_q),
        .qos(qos_d), .tbl(tbl_d)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_IDLE:  state_d = in_valid ? OUT_ISSUE : OUT_IDLE;
            OUT_ISSUE: state_d = in_valid ? OUT_ISSUE : OUT_IDLE;
            default:   state_d = OUT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= OUT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_qos   <= '0;
            out_table <= '0;
        end else if (in_valid) begin
            out_qos   <= qos_d;
            out_table <= tbl_d;
        end
    end

    assign out_valid = (state_q == OUT_ISSUE);
endmodule

// File: rtl/qos_remap_chk.sv
module qos_remap_chk #(
    parameter int PRIO_W    = 3,
    parameter int QOS_W     = 4,
    parameter int NUM_RANGE = 3,
    parameter int ADDR_W    = 4,
    localparam int SEL_W    = $clog2(NUM_RANGE + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [PRIO_W-1:0] in_prio,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              filt_en_bit,
    input logic              out_valid,
    input logic [QOS_W-1:0]  out_qos,
    input logic [SEL_W-1:0]  out_sel
);
    localparam int TAB_BASE = 2**(ADDR_W-1);

    logic filt_en_seen;
    logic tab_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            filt_en_seen <= 1'b0;
            tab_seen     <= 1'b0;
        end else begin
            if (reg_we && reg_addr < ADDR_W'(NUM_RANGE) && filt_en_bit)
                filt_en_seen <= 1'b1;
            if (reg_we && reg_addr >= ADDR_W'(TAB_BASE))
                tab_seen <= 1'b1;
        end
    end

    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_qos) && $stable(out_sel)));

    // R6
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> !out_valid);

    // R6
    default_only_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !filt_en_seen) |-> (out_sel == '0));

    // R6
    identity_map_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !tab_seen) |=> (out_qos == QOS_W'($past(in_prio))));
endmodule

bind qos_remap_top qos_remap_chk #(
    .PRIO_W(PRIO_W), .QOS_W(QOS_W), .NUM_RANGE(NUM_RANGE), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_prio(in_prio),
    .reg_we(reg_we), .reg_addr(reg_addr), .filt_en_bit(reg_wdata[2*ROUTE_W]),
    .out_valid(out_valid), .out_qos(out_qos),
    .out_sel(out_table[$clog2(NUM_RANGE+1)-1:0])
);

// File: tb/test_qos_remap_top.sv
module test_qos_remap_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [11:0] in_route = '0;
    logic        in_class = 1'b0;
    logic [2:0]  in_prio = '0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        out_valid;
    logic [3:0]  out_qos;
    logic [2:0]  out_table;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    logic [31:0] m_filt [3];
    logic [31:0] m_tab  [8];
    logic [6:0]  exp_q [$];
    string       tag_q [$];
    int          stamp_q [$];

    qos_remap_top i_qos_remap_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_route(in_route),
        .in_class(in_class), .in_prio(in_prio), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .out_valid(out_valid), .out_qos(out_qos), .out_table(out_table)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc++;

    function automatic logic [6:0] model(logic [11:0] r, logic c, logic [2:0] p);
        logic [1:0] sel = 2'd0;
        for (int k = 2; k >= 0; k--) begin
            if (m_filt[k][24] && (((r ^ m_filt[k][11:0]) & m_filt[k][23:12]) == 12'd0))
                sel = 2'(k + 1);
        end
        return {c, sel, m_tab[{c, sel}][p*4 +: 4]};
    endfunction

    task automatic model_write(logic [3:0] a, logic [31:0] d);
        if (a < 4'd3) m_filt[a] = d & 32'h01FF_FFFF;
        else if (a >= 4'd8) m_tab[a - 4'd8] = d;
    endtask

    task automatic push_exp(logic [11:0] r, logic c, logic [2:0] p, string tag);
        exp_q.push_back(model(r, c, p));
        tag_q.push_back(tag);
        stamp_q.push_back(cyc);
    endtask

    task automatic lookup(logic [11:0] r, logic c, logic [2:0] p, string tag);
        push_exp(r, c, p, tag);
        in_valid = 1'b1; in_route = r; in_class = c; in_prio = p;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic reg_write(logic [3:0] a, logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        model_write(a, d);
    endtask

    task automatic write_and_lookup(logic [3:0] a, logic [31:0] d,
                                    logic [11:0] r, logic c, logic [2:0] p, string tag);
        push_exp(r, c, p, tag);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        in_valid = 1'b1; in_route = r; in_class = c; in_prio = p;
        @(negedge clk);
        reg_we = 1'b0; in_valid = 1'b0;
        model_write(a, d);
    endtask

    task automatic reg_check(logic [3:0] a, logic [31:0] exp, string tag);
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            fails++;
            $display("FAIL %s: read addr %0d got %h expected %h", tag, a, reg_rdata, exp);
        end
        @(negedge clk);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R7: out_valid=1 expected 0 (no request pending)");
                end else begin
                    logic [6:0] e;
                    string t;
                    int s;
                    e = exp_q.pop_front(); t = tag_q.pop_front(); s = stamp_q.pop_front();
                    if (s != cyc - 1 || {out_table, out_qos} !== e) begin
                        fails++;
                        $display("FAIL %s: got table=%0d qos=%h expected table=%0d qos=%h (issued cycle %0d, now %0d)",
                                 t, out_table, out_qos, e[6:4], e[3:0], s, cyc);
                    end
                end
            end else if (exp_q.size() != 0 && stamp_q[0] < cyc) begin
                checks++;
                fails++;
                $display("FAIL R7: out_valid=0 expected 1 for %s", tag_q[0]);
                void'(exp_q.pop_front()); void'(tag_q.pop_front()); void'(stamp_q.pop_front());
            end
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R7: watchdog expired, got hang expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 3; k++) m_filt[k] = '0;
        for (int t = 0; t < 8; t++) m_tab[t] = 32'h7654_3210;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R6: reset state
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R6: out_valid got %b expected 0", out_valid);
        end
        for (int k = 0; k < 3; k++) reg_check(4'(k), 32'h0, "R6");
        for (int t = 0; t < 8; t++) reg_check(4'(8 + t), 32'h7654_3210, "R6");

        // R6 identity, R2 default, R4 class
        for (int p = 0; p < 8; p++) lookup(12'h123, 1'b0, 3'(p), "R6");
        lookup(12'h123, 1'b1, 3'd5, "R4");
        idle(2);

        // R9, R5: program distinctive tables and read back
        for (int t = 0; t < 8; t++) begin
            logic [31:0] w;
            for (int i = 0; i < 8; i++) w[i*4 +: 4] = 4'((i*5 + t*3 + 1) & 15);
            reg_write(4'(8 + t), w);
        end
        for (int t = 0; t < 8; t++) reg_check(4'(8 + t), m_tab[t], "R9");

        // R5, R2, R4: back-to-back lookups over all priorities and both classes
        for (int p = 0; p < 8; p++) begin
            lookup(12'h0A0, 1'b0, 3'(p), "R5");
            lookup(12'h0A0, 1'b1, 3'(p), "R4");
        end
        idle(2);

        // R1: program filters
        reg_write(4'd0, (32'd1 << 24) | (32'hF00 << 12) | 32'h100);
        reg_write(4'd1, (32'd1 << 24) | (32'hFF0 << 12) | 32'h120);
        reg_write(4'd2, (32'd1 << 24) | (32'hFFF << 12) | 32'h5A5);
        reg_check(4'd1, 32'h01FF_0120, "R1");
        lookup(12'h1A3, 1'b0, 3'd2, "R1");
        lookup(12'h123, 1'b1, 3'd7, "R3");
        lookup(12'h5A5, 1'b0, 3'd4, "R1");
        lookup(12'h200, 1'b1, 3'd1, "R2");
        lookup(12'h5A4, 1'b0, 3'd4, "R2");
        idle(1);

        // R3: disable range 1 so range 2 wins next
        reg_write(4'd0, (32'hF00 << 12) | 32'h100);
        lookup(12'h123, 1'b0, 3'd3, "R3");
        lookup(12'h1A3, 1'b1, 3'd6, "R1");
        // R1: zero mask matches any route
        reg_write(4'd2, (32'd1 << 24) | 32'h5A5);
        lookup(12'h777, 1'b1, 3'd6, "R1");
        lookup(12'h124, 1'b0, 3'd0, "R3");
        reg_write(4'd2, 32'h0);
        idle(1);

        // R8: write and lookup in the same cycle
        write_and_lookup(4'd8, 32'hFEDC_BA98, 12'h300, 1'b0, 3'd1, "R8");
        lookup(12'h300, 1'b0, 3'd1, "R8");
        write_and_lookup(4'd1, (32'd1 << 24) | (32'hFFF << 12) | 32'h300,
                         12'h300, 1'b1, 3'd2, "R8");
        lookup(12'h300, 1'b1, 3'd2, "R8");
        idle(2);

        // R9: ignored addresses, truncated filter read
        reg_write(4'd3, 32'hFFFF_FFFF);
        reg_write(4'd7, 32'hFFFF_FFFF);
        reg_write(4'd4, 32'h1234_5678);
        reg_check(4'd3, 32'h0, "R9");
        reg_check(4'd7, 32'h0, "R9");
        reg_check(4'd4, 32'h0, "R9");
        for (int t = 0; t < 8; t++) reg_check(4'(8 + t), m_tab[t], "R9");
        reg_write(4'd1, 32'hFFFF_FFFF);
        reg_check(4'd1, 32'h01FF_FFFF, "R9");
        lookup(12'hFFF, 1'b1, 3'd0, "R9");
        lookup(12'hFFE, 1'b1, 3'd0, "R9");
        idle(3);

        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R7: %0d results outstanding, expected 0", exp_q.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule